// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block is a passive, synchronous observer for the command pins of a single-bank SDR SDRAM. Every clock, it decodes chip select, row strobe, column strobe and write enable into a command. It then decides whether that command is permitted in the state the device is in, and advances a model of the device state.

The model has eight states:

- idle
- row active
- write burst
- write recovering
- write recovering with auto precharge
- precharging
- auto refreshing
- mode register setting

Four timing values are supplied as inputs: the row-to-column delay, the precharge time, the refresh cycle time and the write recovery time. The write burst length is also an input. The state model uses these values to time the exits from the timed states.

The monitor sits beside a memory controller, or in a test environment, and raises a one-cycle flag for every command that breaks the protocol. The clock-enable pin gates decoding. When clock enable was low at the previous edge, the monitor freezes its model and reports a suspended code.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cke` high at the previous edge, each edge registers a command code on `cmd_o`. The code is DESL=0 when `cs_n` is high. When `cs_n` is low, {ras_n,cas_n,we_n} decodes as follows: 111 gives NOP=1, 110 gives BST=2, 101 gives READ=3, 100 gives WRIT=4, 011 gives ACT=5, 010 gives PRE=6, 001 gives REF=7, and 000 gives MRS=8.
- R2: When `cke` was low at the previous edge, `cmd_o` shows 9, `illegal_o` is 0, and the state and all timers hold.
- R3: In idle (state 0), ACT leads to row active (1), REF leads to auto refreshing (6), and MRS leads to mode register setting (7). READ and WRIT are flagged illegal.
- R4: In row active, READ and WRIT are illegal until `t_rcd` cycles have passed since ACT. A legal WRIT enters write burst (2) for `burst_len` cycles, with A10 recorded as auto precharge. PRE moves to precharging (5). ACT, REF and MRS are illegal.
- R5: When a burst ends, the state moves to write recovering with auto precharge (4) if A10 was 1, and to write recovering (3) if A10 was 0. BST during a burst without auto precharge ends it at once into state 3.
- R6: In write recovering, DESL, NOP and BST are no-ops, and the state reaches row active after `t_dpl` cycles. READ starts a read: it goes to row active if A10=0 and to precharging if A10=1. WRIT starts a new burst, with A10 setting auto precharge.
- R7: In write recovering, ACT, PRE, REF and MRS are flagged illegal.
- R8: In write recovering with auto precharge, every command except DESL, NOP and BST is illegal. The state reaches precharging after `t_dpl` cycles.
- R9: Precharging returns to idle after `t_rp` cycles. Any command other than DESL, NOP and BST is illegal there.
- R10: Auto refreshing returns to idle after `t_rc` cycles. Any command other than DESL, NOP and BST is illegal there.
- R11: Mode register setting returns to idle after exactly 2 clocks. BST and all commands other than DESL and NOP are illegal there.
- R12: `illegal_o` is registered and is high for one cycle per illegal command. An illegal command acts as a NOP: it changes no state, although a timer running in that cycle still counts and may expire.
- R13: A synchronous reset (`rst` high) forces idle, clears `illegal_o` and sets `cmd_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10 (auto precharge select) |
| t_rcd | input | CW | Row-to-column delay in cycles |
| t_rp | input | CW | Precharge time in cycles |
| t_rc | input | CW | Refresh cycle time in cycles |
| t_dpl | input | CW | Write recovery time in cycles |
| burst_len | input | CW | Write burst length in cycles |
| state_o | output | 3 | Tracked device state |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | One-cycle illegal-command flag |

## Verification
A timed exit and an illegal-command rejection can both happen on the same edge. The bench provokes this in three places. It issues ACT on the last cycle of write recovery, READ on the last cycle of write recovery with auto precharge, and MRS on the last refresh cycle. In each case it expects the flag to be raised and the state to advance to the timer's target anyway. The scoreboard judges both outputs from the same popped item, so losing either effect is reported.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          a10,
  input  logic [CW-1:0] t_rcd,
  input  logic [CW-1:0] t_rp,
  input  logic [CW-1:0] t_rc,
  input  logic [CW-1:0] t_dpl,
  input  logic [CW-1:0] burst_len,
  output logic [2:0]    state_o,
  output logic [3:0]    cmd_o,
  output logic          illegal_o
);
  localparam logic [3:0] C_DESL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_READ = 4'd3,
                         C_WRIT = 4'd4, C_ACT = 4'd5, C_PRE = 4'd6, C_REF = 4'd7,
                         C_MRS  = 4'd8, C_SUSP = 4'd9;
  localparam logic [2:0] S_IDLE = 3'd0, S_ACT = 3'd1, S_WBURST = 3'd2, S_WREC = 3'd3,
                         S_WRECAP = 3'd4, S_PRECH = 3'd5, S_AREF = 3'd6, S_MRSET = 3'd7;
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [2:0]    state, nxt;
  logic [CW-1:0] cnt, cnt_n, rcd, rcd_n;
  logic          ap, ap_n, cke_q, legal, nopc;
  logic [3:0]    cmd, eff;

  wire [CW-1:0] ld_rcd = (t_rcd == ZERO) ? ZERO : t_rcd - ONE;
  wire [CW-1:0] ld_rp  = (t_rp  == ZERO) ? ZERO : t_rp  - ONE;
  wire [CW-1:0] ld_rc  = (t_rc  == ZERO) ? ZERO : t_rc  - ONE;
  wire [CW-1:0] ld_dpl = (t_dpl == ZERO) ? ZERO : t_dpl - ONE;
  wire [CW-1:0] ld_bl  = (burst_len == ZERO) ? ZERO : burst_len - ONE;
  wire          expire = (cnt == ZERO);

  always_comb begin
    if (cs_n) cmd = C_DESL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b110:  cmd = C_BST;
        3'b101:  cmd = C_READ;
        3'b100:  cmd = C_WRIT;
        3'b011:  cmd = C_ACT;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        default: cmd = C_MRS;
      endcase
    end
  end

  assign nopc = (cmd == C_DESL) || (cmd == C_NOP) || (cmd == C_BST);

  always_comb begin
    legal = 1'b1;
    case (state)
      S_IDLE:   legal = !(cmd == C_READ || cmd == C_WRIT);
      S_ACT:    legal = !(cmd == C_ACT || cmd == C_REF || cmd == C_MRS ||
                          ((cmd == C_READ || cmd == C_WRIT) && rcd != ZERO));
      S_WBURST: legal = !(cmd == C_ACT || cmd == C_PRE || cmd == C_REF || cmd == C_MRS ||
                          (ap && (cmd == C_READ || cmd == C_WRIT || cmd == C_BST)));
      S_WREC:   legal = !(cmd == C_ACT || cmd == C_PRE || cmd == C_REF || cmd == C_MRS);
      S_MRSET:  legal = (cmd == C_DESL) || (cmd == C_NOP);
      default:  legal = nopc;
    endcase
  end

  assign eff = legal ? cmd : C_NOP;

  always_comb begin
    nxt   = state;
    cnt_n = expire ? cnt : cnt - ONE;
    ap_n  = ap;
    rcd_n = (rcd == ZERO) ? rcd : rcd - ONE;
    case (state)
      S_IDLE: begin
        if (eff == C_ACT) begin nxt = S_ACT; rcd_n = ld_rcd; end
        else if (eff == C_REF) begin nxt = S_AREF; cnt_n = ld_rc; end
        else if (eff == C_MRS) begin nxt = S_MRSET; cnt_n = ONE; end
      end
      S_ACT, S_WBURST, S_WREC: begin
        if (eff == C_READ) begin
          if (a10) begin nxt = S_PRECH; cnt_n = ld_rp; end
          else nxt = S_ACT;
        end else if (eff == C_WRIT) begin
          nxt = S_WBURST; cnt_n = ld_bl; ap_n = a10;
        end else if (eff == C_PRE) begin
          nxt = S_PRECH; cnt_n = ld_rp;
        end else if (state == S_WBURST && (eff == C_BST || expire)) begin
          nxt = (ap && eff != C_BST) ? S_WRECAP : S_WREC; cnt_n = ld_dpl;
        end else if (state == S_WREC && expire) begin
          nxt = S_ACT;
        end
      end
      S_WRECAP: if (expire) begin nxt = S_PRECH; cnt_n = ld_rp; end
      default:  if (expire) nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) cke_q <= cke;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cnt <= ZERO; rcd <= ZERO; ap <= 1'b0;
      illegal_o <= 1'b0; cmd_o <= C_DESL;
    end else if (!cke_q) begin
      illegal_o <= 1'b0; cmd_o <= C_SUSP;
    end else begin
      state <= nxt; cnt <= cnt_n; rcd <= rcd_n; ap <= ap_n;
      illegal_o <= !legal; cmd_o <= cmd;
    end
  end

  assign state_o = state;

  a_r13_reset_idle: assert property (@(posedge clk)
    rst |=> (state_o == S_IDLE && !illegal_o && cmd_o == C_DESL));
  a_r2_suspend_freeze: assert property (@(posedge clk) disable iff (rst)
    !cke_q |=> ($stable(state_o) && !illegal_o && cmd_o == C_SUSP));
  a_r3_idle_rdwr_flag: assert property (@(posedge clk) disable iff (rst)
    (cke_q && state_o == S_IDLE && !cs_n && ras_n && !cas_n) |=> illegal_o);
  a_r12_untimed_hold: assert property (@(posedge clk) disable iff (rst)
    (illegal_o && ($past(state_o) == S_IDLE || $past(state_o) == S_ACT)) |-> state_o == $past(state_o));
  a_r8_wrecap_exit: assert property (@(posedge clk) disable iff (rst)
    state_o == S_WRECAP |=> (state_o == S_WRECAP || state_o == S_PRECH));
  a_r10_aref_exit: assert property (@(posedge clk) disable iff (rst)
    state_o == S_AREF |=> (state_o == S_AREF || state_o == S_IDLE));
  a_r11_mrs_exit: assert property (@(posedge clk) disable iff (rst)
    state_o == S_MRSET |=> (state_o == S_MRSET || state_o == S_IDLE));
  a_r7_wrec_targets: assert property (@(posedge clk) disable iff (rst)
    state_o == S_WREC |=> (state_o != S_IDLE && state_o != S_AREF && state_o != S_MRSET && state_o != S_WRECAP));
endmodule

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
  localparam int CW = 4;
  logic clk = 1'b0, rst = 1'b1, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [CW-1:0] t_rcd = 4'd2, t_rp = 4'd3, t_rc = 4'd4, t_dpl = 4'd2, burst_len = 4'd2;
  logic [2:0] state_o;
  logic [3:0] cmd_o;
  logic       illegal_o;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.CW(CW)) u_sdram_cmd_monitor (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .a10(a10), .t_rcd(t_rcd), .t_rp(t_rp), .t_rc(t_rc), .t_dpl(t_dpl),
    .burst_len(burst_len), .state_o(state_o), .cmd_o(cmd_o), .illegal_o(illegal_o));

  localparam logic [3:0] DESL = 0, NOP = 1, BST = 2, RD = 3, WR = 4, ACT = 5, PRE = 6, REF = 7, MRS = 8, SUSP = 9;
  localparam logic [2:0] IDLE = 0, ROW = 1, BURST = 2, WREC = 3, WRECAP = 4, PRECH = 5, AREF = 6, MSET = 7;

  task automatic step(input logic [3:0] c, input logic a, input logic ck,
                      input logic [2:0] es, input logic [3:0] ec, input logic ei, input string tag);
    cke = ck; a10 = a; cs_n = (c == DESL);
    case (c)
      BST: {ras_n, cas_n, we_n} = 3'b110;
      RD:  {ras_n, cas_n, we_n} = 3'b101;
      WR:  {ras_n, cas_n, we_n} = 3'b100;
      ACT: {ras_n, cas_n, we_n} = 3'b011;
      PRE: {ras_n, cas_n, we_n} = 3'b010;
      REF: {ras_n, cas_n, we_n} = 3'b001;
      MRS: {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    exp_q.push_back({es, ec, ei});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({state_o, cmd_o, illegal_o} !== e) begin
        fails++;
        $display("FAIL %s: state/cmd/illegal got %0d/%0d/%0d expected %0d/%0d/%0d",
                 t, state_o, cmd_o, illegal_o, e[7:5], e[4:1], e[0]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (state_o !== IDLE || illegal_o !== 1'b0 || cmd_o !== DESL) begin
      fails++;
      $display("FAIL R13: reset state/cmd/illegal got %0d/%0d/%0d expected 0/0/0", state_o, cmd_o, illegal_o);
    end
    rst = 1'b0;
    step(NOP, 0, 1, IDLE,  NOP, 0, "R1 nop idle");
    step(RD,  0, 1, IDLE,  RD,  1, "R3 read in idle");
    step(ACT, 0, 1, ROW,   ACT, 0, "R3 act");
    step(RD,  0, 1, ROW,   RD,  1, "R4 read before trcd");
    step(WR,  0, 1, BURST, WR,  0, "R4 write");
    step(NOP, 0, 1, BURST, NOP, 0, "R4 burst len");
    step(NOP, 0, 1, WREC,  NOP, 0, "R5 burst end plain");
    step(DESL,0, 1, WREC,  DESL,0, "R6 desl in wrec");
    step(ACT, 0, 1, ROW,   ACT, 1, "R7 act in wrec at expiry");
    step(WR,  1, 1, BURST, WR,  0, "R4 write ap");
    step(NOP, 0, 1, BURST, NOP, 0, "R5 burst ap");
    step(NOP, 0, 1, WRECAP,NOP, 0, "R5 burst end ap");
    step(BST, 0, 1, WRECAP,BST, 0, "R8 bst nop");
    step(RD,  0, 1, PRECH, RD,  1, "R8 read at expiry");
    step(PRE, 0, 1, PRECH, PRE, 1, "R9 pre in precharging");
    step(NOP, 0, 1, PRECH, NOP, 0, "R9 count");
    step(NOP, 0, 1, IDLE,  NOP, 0, "R9 trp exit");
    step(REF, 0, 1, AREF,  REF, 0, "R3 refresh");
    step(NOP, 0, 1, AREF,  NOP, 0, "R10 count");
    step(WR,  0, 1, AREF,  WR,  1, "R10 write illegal");
    step(NOP, 0, 1, AREF,  NOP, 0, "R10 count");
    step(MRS, 0, 1, IDLE,  MRS, 1, "R12 mrs at trc expiry");
    step(MRS, 0, 1, MSET,  MRS, 0, "R3 mrs");
    step(BST, 0, 1, MSET,  BST, 1, "R11 bst illegal");
    step(NOP, 0, 1, IDLE,  NOP, 0, "R11 two clocks");
    step(ACT, 0, 1, ROW,   ACT, 0, "R3 act");
    step(ACT, 0, 1, ROW,   ACT, 1, "R12 act in row hold");
    step(WR,  0, 1, BURST, WR,  0, "R4 write");
    step(BST, 0, 1, WREC,  BST, 0, "R5 bst ends burst");
    step(RD,  0, 1, ROW,   RD,  0, "R6 read from wrec");
    step(WR,  0, 1, BURST, WR,  0, "R4 write");
    step(NOP, 0, 1, BURST, NOP, 0, "R4 burst");
    step(NOP, 0, 1, WREC,  NOP, 0, "R5 burst end");
    step(WR,  1, 1, BURST, WR,  0, "R6 new write ap from wrec");
    step(NOP, 0, 1, BURST, NOP, 0, "R5 burst");
    step(NOP, 0, 1, WRECAP,NOP, 0, "R5 to wrecap");
    step(NOP, 0, 1, WRECAP,NOP, 0, "R8 count");
    step(NOP, 0, 1, PRECH, NOP, 0, "R8 tdpl exit");
    step(NOP, 0, 1, PRECH, NOP, 0, "R9 count");
    step(NOP, 0, 1, PRECH, NOP, 0, "R9 count");
    step(NOP, 0, 1, IDLE,  NOP, 0, "R9 exit");
    step(ACT, 0, 1, ROW,   ACT, 0, "R3 act");
    step(NOP, 0, 0, ROW,   NOP, 0, "R2 cke falls");
    step(PRE, 0, 0, ROW,   SUSP,0, "R2 suspended pre");
    step(RD,  0, 1, ROW,   SUSP,0, "R2 suspended read");
    step(PRE, 0, 1, PRECH, PRE, 0, "R4 pre");
    step(NOP, 0, 1, PRECH, NOP, 0, "R9 count");
    step(NOP, 0, 1, PRECH, NOP, 0, "R9 count");
    step(DESL,0, 1, IDLE,  DESL,0, "R1 desl");
    step(ACT, 0, 1, ROW,   ACT, 0, "R3 act");
    step(NOP, 0, 1, ROW,   NOP, 0, "R4 wait");
    step(RD,  1, 1, PRECH, RD,  0, "R4 read ap");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule